// File: doc/BRIEF.md
# Segment Offset Translator and Access Checker

This unit turns an offset inside a memory segment into a 32-bit linear address and decides in the same step whether the access is allowed. The caller presents the cached description of the segment: its byte base, a 20-bit raw limit, a granularity flag, a growth-direction flag, a size flag, a presence flag, a code/data flag and one permission flag. It also presents the kind of access and the offset, and raises a one-cycle request strobe.

One clock later the unit returns a registered result with a one-cycle completion pulse. The result holds the linear address and at most one fault flag: the segment is absent, the access kind is not allowed by the segment type, or the offset lies outside the legal window. The address is produced even when a fault is flagged, so the caller can report it.

A two-state controller sequences the result. `ST_IDLE` is the reset state and the state between requests. A strobe in either state moves the controller to `ST_DONE`, in which the completion pulse is high. From `ST_DONE` a new strobe keeps it in `ST_DONE` (back-to-back requests), and no strobe returns it to `ST_IDLE`. The results are captured on every strobe and held unchanged between strobes.

Top module: `seg_xlate`

## Requirements
- R1: `done` is high in the cycle after each cycle in which `req_valid` is high, and low in the cycle after any cycle in which `req_valid` is low. Back-to-back strobes give back-to-back results, in order.
- R2: `lin_addr` equals `seg_base + offset` modulo 2^32, so the sum wraps past 0xFFFFFFFF. It is driven whether or not a fault is flagged, and it holds its value between strobes.
- R3: With `seg_gran`=1 the effective limit is `seg_limit` shifted left by 12 with the low 12 bits set to one. With `seg_gran`=0 it is `seg_limit` zero-extended. The base is never scaled.
- R4: For an expand-up segment, an offset is inside the window only when it is less than or equal to the effective limit.
- R5: For a data segment with `seg_down`=1, an offset is inside the window only when it is strictly greater than the effective limit and not above the top bound. The top bound is 0xFFFFFFFF when `seg_big`=1 and 0x0000FFFF when `seg_big`=0.
- R6: With `seg_present`=0, every access kind raises `flt_np`.
- R7: The encoding of `acc_kind` is 2'b00 read, 2'b01 write, 2'b10 execute, and 2'b11 reserved. The reserved value always raises a type fault. A data segment (`seg_code`=0) allows read, refuses execute, and allows write only when `seg_rw`=1.
- R8: A code segment (`seg_code`=1) allows execute, refuses write, and allows read only when `seg_rw`=1.
- R9: For code segments `seg_down` has no effect, and the window check is the expand-up rule.
- R10: Faults are ranked: `flt_np` first, then `flt_type`, then `flt_limit`. Only the highest-ranked fault is raised, so at most one flag is high.
- R11: After reset, `done`, all three fault flags and `lin_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| seg_base | input | 32 | Segment base, in bytes |
| seg_limit | input | 20 | Raw segment limit |
| seg_gran | input | 1 | 1: limit counts in 4 KiB pages |
| seg_down | input | 1 | 1: data segment grows downward |
| seg_big | input | 1 | Size flag; sets the top bound of an expand-down segment |
| seg_present | input | 1 | Segment present |
| seg_code | input | 1 | 1: code segment, 0: data segment |
| seg_rw | input | 1 | Write permission for data, read permission for code |
| acc_kind | input | 2 | Access kind (see R7) |
| offset | input | 32 | Offset inside the segment |
| done | output | 1 | Result valid pulse |
| lin_addr | output | 32 | Linear address |
| flt_np | output | 1 | Segment-absent fault |
| flt_type | output | 1 | Access-type fault |
| flt_limit | output | 1 | Window fault |

## Verification
Several properties are checked by assertions on every cycle: the completion pulse follows the strobe one cycle later, at most one fault flag is high, an absent segment always reports the absent fault, a write to a code segment always reports a type fault, and the address holds still between strobes. Other behaviour only shows up in the bench scenarios. These scenarios cover the exact window edges under both granularities, the expand-down window for both size flags, address wraparound, the `seg_down` flag having no effect on code segments, and the ranking of faults when several causes are present at once.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } xl_state_e;

    typedef struct packed {
        logic np;
        logic ty;
        logic lim;
    } flt_t;

endpackage

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
    parameter int ADDR_W  = 32,
    parameter int LIM_W   = 20,
    parameter int GRAN_SH = 12,
    parameter int SMALL_W = 16
) (
    input  logic [LIM_W-1:0]  lim_raw,
    input  logic              gran,
    input  logic              down_eff,
    input  logic              big,
    input  logic [ADDR_W-1:0] ofs,
    output logic              in_window
);
    localparam logic [ADDR_W-1:0] LOW_MASK  = (ADDR_W'(1) << GRAN_SH) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] SMALL_TOP = (ADDR_W'(1) << SMALL_W) - ADDR_W'(1);

    logic [ADDR_W-1:0] eff_lim;
    logic [ADDR_W-1:0] top_bound;

    always_comb begin
        if (gran) begin
            eff_lim = (ADDR_W'(lim_raw) << GRAN_SH) | LOW_MASK;
        end else begin
            eff_lim = ADDR_W'(lim_raw);
        end
        top_bound = big ? '1 : SMALL_TOP;
        if (down_eff) begin
            in_window = (ofs > eff_lim) && (ofs <= top_bound);
        end else begin
            in_window = (ofs <= eff_lim);
        end
    end

endmodule

// File: rtl/seg_type_chk.sv
module seg_type_chk
    import seg_xlate_pkg::*;
(
    input  logic      is_code,
    input  logic      perm,
    input  acc_kind_e kind,
    output logic      type_ok
);
    always_comb begin
        unique case (kind)
            ACC_READ:  type_ok = is_code ? perm : 1'b1;
            ACC_WRITE: type_ok = is_code ? 1'b0 : perm;
            ACC_EXEC:  type_ok = is_code;
            ACC_RSVD:  type_ok = 1'b0;
            default:   type_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LIM_W   = 20,
    parameter int GRAN_SH = 12,
    parameter int SMALL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [LIM_W-1:0]  seg_limit,
    input  logic              seg_gran,
    input  logic              seg_down,
    input  logic              seg_big,
    input  logic              seg_present,
    input  logic              seg_code,
    input  logic              seg_rw,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] offset,
    output logic              done,
    output logic [ADDR_W-1:0] lin_addr,
    output logic              flt_np,
    output logic              flt_type,
    output logic              flt_limit
);
    xl_state_e state_q, state_d;
    logic      win_ok, type_ok;
    flt_t      flt_c, flt_q;

    // Only data segments may grow downward.
    seg_limit_chk #(
        .ADDR_W (ADDR_W),
        .LIM_W  (LIM_W),
        .GRAN_SH(GRAN_SH),
        .SMALL_W(SMALL_W)
    ) u_lim (
        .lim_raw  (seg_limit),
        .gran     (seg_gran),
        .down_eff (seg_down && !seg_code),
        .big      (seg_big),
        .ofs      (offset),
        .in_window(win_ok)
    );

    seg_type_chk u_type (
        .is_code(seg_code),
        .perm   (seg_rw),
        .kind   (acc_kind_e'(acc_kind)),
        .type_ok(type_ok)
    );

    // Ranked fault selection.
    always_comb begin
        flt_c.np  = !seg_present;
        flt_c.ty  = seg_present && !type_ok;
        flt_c.lim = seg_present && type_ok && !win_ok;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = req_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_addr <= '0;
            flt_q    <= '0;
        end else if (req_valid) begin
            lin_addr <= seg_base + offset;
            flt_q    <= flt_c;
        end
    end

    assign done      = (state_q == ST_DONE);
    assign flt_np    = flt_q.np;
    assign flt_type  = flt_q.ty;
    assign flt_limit = flt_q.lim;

    // R1
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);
    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done);
    // R10
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flt_np, flt_type, flt_limit}));
    // R6
    absent_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !seg_present) |=> flt_np);
    // R8
    code_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && seg_present && seg_code && acc_kind == 2'b01) |=> flt_type);
    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(lin_addr));

endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] seg_base = '0;
    logic [19:0] seg_limit = '0;
    logic        seg_gran = 1'b0, seg_down = 1'b0, seg_big = 1'b0;
    logic        seg_present = 1'b0, seg_code = 1'b0, seg_rw = 1'b0;
    logic [1:0]  acc_kind = 2'b00;
    logic [31:0] offset = '0;
    logic        done;
    logic [31:0] lin_addr;
    logic        flt_np, flt_type, flt_limit;

    int checks = 0;
    int errors = 0;

    logic [34:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .seg_base(seg_base), .seg_limit(seg_limit), .seg_gran(seg_gran),
        .seg_down(seg_down), .seg_big(seg_big), .seg_present(seg_present),
        .seg_code(seg_code), .seg_rw(seg_rw), .acc_kind(acc_kind),
        .offset(offset), .done(done), .lin_addr(lin_addr),
        .flt_np(flt_np), .flt_type(flt_type), .flt_limit(flt_limit)
    );

    // Expected result {np, type, limit, addr} from the requirements.
    function automatic logic [34:0] model(
        input logic [31:0] b, input logic [19:0] l, input logic g,
        input logic dn, input logic bg, input logic p, input logic c,
        input logic rw, input logic [1:0] k, input logic [31:0] o);
        logic [31:0] lim, top, a;
        logic ok_t, ok_w, e_np, e_ty, e_li;
        lim = g ? {l, 12'hFFF} : {12'h000, l};
        top = bg ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        if (dn && !c) ok_w = (o > lim) && (o <= top);
        else          ok_w = (o <= lim);
        case (k)
            2'b00:   ok_t = c ? rw : 1'b1;
            2'b01:   ok_t = c ? 1'b0 : rw;
            2'b10:   ok_t = c;
            default: ok_t = 1'b0;
        endcase
        a = b + o;
        e_np = !p;
        e_ty = p && !ok_t;
        e_li = p && ok_t && !ok_w;
        return {e_np, e_ty, e_li, a};
    endfunction

    task automatic send(input logic [31:0] b, input logic [19:0] l,
        input logic g, input logic dn, input logic bg, input logic p,
        input logic c, input logic rw, input logic [1:0] k,
        input logic [31:0] o, input string tag);
        @(negedge clk);
        seg_base = b; seg_limit = l; seg_gran = g; seg_down = dn;
        seg_big = bg; seg_present = p; seg_code = c; seg_rw = rw;
        acc_kind = k; offset = o; req_valid = 1'b1;
        exp_q.push_back(model(b, l, g, dn, bg, p, c, rw, k, o));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard on each result pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1: done=1 with no pending request, expected done=0");
            end else begin
                logic [34:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({flt_np, flt_type, flt_limit, lin_addr} !== e) begin
                    errors++;
                    $display("FAIL %s: got np/ty/li=%b%b%b addr=%h, expected %b%b%b addr=%h",
                             t, flt_np, flt_type, flt_limit, lin_addr,
                             e[34], e[33], e[32], e[31:0]);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({done, flt_np, flt_type, flt_limit, lin_addr} !== '0) begin
            errors++;
            $display("FAIL R11: got done/flags/addr=%b%b%b%b %h, expected all zero",
                     done, flt_np, flt_type, flt_limit, lin_addr);
        end

        // R4 byte granularity, edge of window
        send(32'h0001_2345, 20'h05678, 0, 0, 0, 1, 0, 1, 2'b00, 32'h0000_5678, "R4");
        send(32'h0001_2345, 20'h05678, 0, 0, 0, 1, 0, 1, 2'b00, 32'h0000_5679, "R4");
        // R3 page granularity, base unscaled
        send(32'h0001_2345, 20'h05678, 1, 0, 0, 1, 0, 1, 2'b01, 32'h0567_8FFF, "R3");
        send(32'h0001_2345, 20'h05678, 1, 0, 0, 1, 0, 1, 2'b01, 32'h0567_9000, "R3");
        idle(2);
        // R1 no pulse while idle
        checks++;
        if (done !== 1'b0) begin
            errors++;
            $display("FAIL R1: done=%b while idle, expected 0", done);
        end
        // R5 expand-down, small and big top bound
        send(32'h0010_0000, 20'h00FFF, 0, 1, 0, 1, 0, 1, 2'b00, 32'h0000_0FFF, "R5");
        send(32'h0010_0000, 20'h00FFF, 0, 1, 0, 1, 0, 1, 2'b00, 32'h0000_1000, "R5");
        send(32'h0010_0000, 20'h00FFF, 0, 1, 0, 1, 0, 1, 2'b00, 32'h0000_FFFF, "R5");
        send(32'h0010_0000, 20'h00FFF, 0, 1, 0, 1, 0, 1, 2'b00, 32'h0001_0000, "R5");
        send(32'h0010_0000, 20'h00FFF, 0, 1, 1, 1, 0, 1, 2'b00, 32'h0001_0000, "R5");
        send(32'h0010_0000, 20'h00FFF, 0, 1, 1, 1, 0, 1, 2'b00, 32'hFFFF_FFFF, "R5");
        send(32'h0000_0000, 20'h00003, 1, 1, 1, 1, 0, 1, 2'b01, 32'h0000_3FFF, "R5");
        // R2 wraparound
        send(32'hFFFF_F000, 20'hFFFFF, 1, 0, 0, 1, 0, 1, 2'b00, 32'h0000_2000, "R2");
        // R6 absent segment, every kind
        send(32'h0000_1000, 20'h00010, 0, 0, 0, 0, 0, 1, 2'b00, 32'h0000_0004, "R6");
        send(32'h0000_1000, 20'h00010, 0, 0, 0, 0, 1, 1, 2'b10, 32'h0000_0004, "R6");
        // R10 absent beats type and limit
        send(32'h0000_1000, 20'h00010, 0, 0, 0, 0, 1, 0, 2'b01, 32'h0000_9999, "R10");
        // R7 data rules
        send(32'h0000_2000, 20'h000FF, 0, 0, 0, 1, 0, 0, 2'b01, 32'h0000_0010, "R7");
        send(32'h0000_2000, 20'h000FF, 0, 0, 0, 1, 0, 0, 2'b00, 32'h0000_0010, "R7");
        send(32'h0000_2000, 20'h000FF, 0, 0, 0, 1, 0, 1, 2'b10, 32'h0000_0010, "R7");
        send(32'h0000_2000, 20'h000FF, 0, 0, 0, 1, 0, 1, 2'b11, 32'h0000_0010, "R7");
        // R8 code rules
        send(32'h0000_3000, 20'h000FF, 0, 0, 0, 1, 1, 1, 2'b01, 32'h0000_0010, "R8");
        send(32'h0000_3000, 20'h000FF, 0, 0, 0, 1, 1, 0, 2'b00, 32'h0000_0010, "R8");
        send(32'h0000_3000, 20'h000FF, 0, 0, 0, 1, 1, 1, 2'b00, 32'h0000_0010, "R8");
        send(32'h0000_3000, 20'h000FF, 0, 0, 0, 1, 1, 0, 2'b10, 32'h0000_00FF, "R8");
        // R9 direction flag ignored for code
        send(32'h0000_3000, 20'h000FF, 0, 1, 0, 1, 1, 0, 2'b10, 32'h0000_0010, "R9");
        send(32'h0000_3000, 20'h000FF, 0, 1, 0, 1, 1, 0, 2'b10, 32'h0000_0100, "R9");
        // R10 type beats limit
        send(32'h0000_3000, 20'h000FF, 0, 0, 0, 1, 1, 0, 2'b01, 32'h0000_0100, "R10");
        idle(3);
        // R1 every request produced a result
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1: %0d results missing, expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule